// File: doc/BRIEF.md
# Byte-Stream Memory Word Loader

This block fills a word-wide data memory from a byte stream. A `start` pulse opens a load. The block then raises `in_ready` and takes one byte per cycle while `in_valid` is high. It packs the bytes into 32-bit words and issues one write per finished word. The first word goes to address zero and each later word goes to the next address. The byte that carries `in_last` closes the load, and a `done` pulse follows it.

There are two framings. The framing input is sampled at `start`. In plain framing a word is four data bytes and every written word is flagged valid. In validity framing a word is five bytes: first a validity byte, then the four data bytes. A validity byte of zero marks the word invalid, and any other value marks it valid. Data bytes are little-endian in both framings.

If the stream ends partway through a word, that word is discarded and an error flag is raised. Once every memory location has been written, later bytes are accepted and dropped, and a second error flag is raised. Both flags hold until the next `start`.

Top module: `byte_word_loader`

## Requirements
- R1: After reset, `in_ready`, `mem_we`, `done`, `err_partial` and `err_overflow` are all 0.
- R2: A load writes its words to consecutive addresses 0, 1, 2 and so on, in stream order.
- R3: The first data byte of a word lands in `mem_wdata[7:0]`, the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R4: With `framed_mode`=1 at `start`, each word takes 5 bytes. The first byte is the validity byte: `mem_wvalid` is 1 when that byte is nonzero and 0 when it is zero.
- R5: With `framed_mode`=0 at `start`, each word takes 4 bytes and `mem_wvalid` is always 1.
- R6: `framed_mode` is used only in the `start` cycle. Changing it during a load changes neither the framing nor the written values.
- R7: Each completed word produces exactly one cycle of `mem_we`, in the cycle right after its final byte is accepted.
- R8: If the byte with `in_last` leaves a word incomplete, no write is issued for that word and `err_partial` is set.
- R9: After DEPTH words have been written, further bytes are accepted, but they cause no writes and they set `err_overflow`.
- R10: `done` is a one-cycle pulse in the cycle after the `in_last` byte is accepted. `in_ready` is 0 in that cycle.
- R11: Outside a load, `in_ready` is 0 and bytes presented on `in_valid` produce no writes.
- R12: `start` clears `err_partial` and `err_overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a load when the block is idle |
| framed_mode | input | 1 | 1: validity byte before each word; 0: plain 4-byte words |
| in_valid | input | 1 | A byte is presented |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | This byte ends the stream |
| in_ready | output | 1 | The block accepts a byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Assembled word |
| mem_wvalid | output | 1 | Valid flag stored with the word |
| done | output | 1 | Load-finished pulse |
| err_partial | output | 1 | Stream ended inside a word |
| err_overflow | output | 1 | Bytes arrived after memory was full |

## Verification
Two situations are hardest to reach from the ports. The first is a stream that ends inside a word. The second is a stream that runs past the last memory location, including the exact point where the final slot fills. The bench reaches both with a sweep over a small memory of 8 words. Word counts run from one up to past the depth, and every possible tail length is combined with each count, in both framings. The framing pin is inverted in the middle of some loads to show it is ignored there.

// File: rtl/byte_word_loader.sv
module byte_word_loader #(
  parameter int DEPTH = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic                                framed_mode,
  input  logic                                in_valid,
  input  logic [7:0]                          in_data,
  input  logic                                in_last,
  output logic                                in_ready,
  output logic                                mem_we,
  output logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] mem_addr,
  output logic [31:0]                         mem_wdata,
  output logic                                mem_wvalid,
  output logic                                done,
  output logic                                err_partial,
  output logic                                err_overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic          active, framed_q, full;
  logic [2:0]    cnt;
  logic [31:0]   shreg;
  logic [7:0]    vbyte;
  logic [AW-1:0] word_idx;

  wire fire     = in_valid & active;
  wire vslot    = framed_q && (cnt == 3'd0);
  wire word_end = cnt == (framed_q ? 3'd4 : 3'd3);
  wire [31:0] next_word = {in_data, shreg[31:8]};

  assign in_ready = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      framed_q     <= 1'b0;
      full         <= 1'b0;
      cnt          <= '0;
      shreg        <= '0;
      vbyte        <= '0;
      word_idx     <= '0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_wvalid   <= 1'b0;
      done         <= 1'b0;
      err_partial  <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      if (!active) begin
        if (start) begin
          active       <= 1'b1;
          framed_q     <= framed_mode;
          full         <= 1'b0;
          cnt          <= '0;
          word_idx     <= '0;
          err_partial  <= 1'b0;
          err_overflow <= 1'b0;
        end
      end else if (fire) begin
        if (full) begin
          err_overflow <= 1'b1;
        end else begin
          if (vslot) vbyte <= in_data;
          else       shreg <= next_word;
          cnt <= word_end ? 3'd0 : cnt + 3'd1;
          if (word_end) begin
            mem_we     <= 1'b1;
            mem_addr   <= word_idx;
            mem_wdata  <= next_word;
            mem_wvalid <= framed_q ? (|vbyte) : 1'b1;
            word_idx   <= word_idx + 1'b1;
            if (word_idx == LAST_IDX) full <= 1'b1;
          end else if (in_last) begin
            err_partial <= 1'b1;
          end
        end
        if (in_last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  a_r7_write_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && in_ready));
  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(full));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_ready_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  a_r5_plain_always_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !framed_q) |-> mem_wvalid);
  a_r8_partial_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_partial) |-> (done && !mem_we));
endmodule

// File: tb/sim_byte_word_loader.sv
module sim_byte_word_loader;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, framed_mode = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_we, mem_wvalid, done, err_partial, err_overflow;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0, failures = 0, writes = 0, cycles = 0;
  bit cur_framed = 0;
  int seed = 0;

  always #10 clk = ~clk;

  byte_word_loader #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .framed_mode(framed_mode),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid),
    .done(done), .err_partial(err_partial), .err_overflow(err_overflow));

  function automatic logic [7:0] dbyte(int w, int b);
    return 8'((w * 37 + b * 11 + seed * 5 + 3) & 255);
  endfunction
  function automatic logic [7:0] vbyte_of(int w);
    return ((w + seed) % 3 == 1) ? 8'h00 : 8'((w * 5 + 1) | 8'h40);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && mem_we) begin
      chk(mem_addr == AW'(writes), "R2 address", mem_addr, writes);
      chk(writes < DEPTH, "R9 write past depth", writes, DEPTH - 1);
      chk(mem_wdata == {dbyte(writes, 3), dbyte(writes, 2), dbyte(writes, 1), dbyte(writes, 0)},
          "R3 data order", mem_wdata,
          {dbyte(writes, 3), dbyte(writes, 2), dbyte(writes, 1), dbyte(writes, 0)});
      if (cur_framed)
        chk(mem_wvalid == (vbyte_of(writes) != 0), "R4 valid flag", mem_wvalid, vbyte_of(writes) != 0);
      else
        chk(mem_wvalid == 1'b1, "R5 valid flag", mem_wvalid, 1);
      writes++;
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_load(bit fr, int nwords, int tail, bit flip);
    int bpw = fr ? 5 : 4;
    int total = nwords * bpw + tail;
    int exp_writes = (nwords < DEPTH) ? nwords : DEPTH;
    bit exp_ovf = total > DEPTH * bpw;
    bit exp_part = !exp_ovf && tail > 0;
    @(negedge clk);
    writes = 0;
    cur_framed = fr;
    start = 1'b1; framed_mode = fr;
    @(negedge clk);
    start = 1'b0;
    if (flip) framed_mode = ~fr;
    chk(in_ready == 1'b1, "R11 ready during load", in_ready, 1);
    chk(!err_partial && !err_overflow, "R12 flags cleared", {err_partial, err_overflow}, 0);
    for (int i = 0; i < total; i++) begin
      int w = i / bpw, p = i % bpw;
      if (i % 7 == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_last = (i == total - 1);
      in_data = fr ? (p == 0 ? vbyte_of(w) : dbyte(w, p - 1)) : dbyte(w, p);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (i == total - 1) begin
        #2;
        chk(done == 1'b1, "R10 done after last", done, 1);
        chk(in_ready == 1'b0, "R10 ready low at done", in_ready, 0);
        chk(mem_we == (tail == 0 && !exp_ovf), "R7 final write", mem_we, tail == 0 && !exp_ovf);
      end
    end
    @(negedge clk);
    #2;
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    chk(writes == exp_writes, fr ? "R4 R6 write count" : "R5 R6 write count", writes, exp_writes);
    chk(err_partial == exp_part, "R8 partial flag", err_partial, exp_part);
    chk(err_overflow == exp_ovf, "R9 overflow flag", err_overflow, exp_ovf);
  endtask

  initial begin
    #5;
    chk(!in_ready && !mem_we && !done && !err_partial && !err_overflow, "R1 reset state",
        {in_ready, mem_we, done, err_partial, err_overflow}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int fr = 0; fr < 2; fr++)
      for (int n = 0; n <= DEPTH + 1; n++)
        for (int t = 0; t < (fr ? 5 : 4); t++)
          if (n + t > 0) begin
            seed = n * 7 + t + fr;
            run_load(fr[0], n, t, (n + t) % 2 == 1);
          end
    // R11: bytes while idle
    writes = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i); in_last = (i == 9);
      #1;
      chk(in_ready == 1'b0, "R11 ready idle", in_ready, 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    #2;
    chk(writes == 0, "R11 no idle writes", writes, 0);
    chk(done == 1'b0, "R11 no idle done", done, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule